// File: doc/BRIEF.md
# Paged Management Register Map

This block is the byte store that sits behind a two-wire management slave. The host sees a 256-byte window. The lower 128 bytes are always mapped, whatever page is selected. They hold identifier, status, latched flags, monitor values, controls, masks and password areas. The upper 128 bytes are banked. A page number written into the last lower byte chooses which upper page answers.

The host side is a byte port with an address, a write strobe, a read strobe and write data. A sequential flag makes the access use an internal pointer instead of the presented address. The device side is a write-only load port. Through it the module's own logic fills the locations that the host may only read, such as monitors, flags and the read-only pages. The device port cannot change host-writable locations. Each byte's access type comes from the address range it falls in. The scratch page is the one upper page that the host can write.

Top module: `mgmt_paged_regmap`

## Requirements
- R1: After synchronous reset every byte reads 00h, the page register reads 00h and `host_rdata` is 00h.
- R2: Lower bytes 86 to 126 can be written by the host and read back unchanged, whatever page is selected. Device-port writes to them are ignored.
- R3: Host writes to lower bytes 0 to 85 are ignored. The device port loads those bytes, and the host reads back the loaded value.
- R4: Lower byte 127 is the page register. The host can write any value to it and read that value back.
- R5: Addresses 128 to 255 are served by the page named in byte 127. Upper page 02h is host read/write scratch space, separate from every other page.
- R6: Upper pages 00h and 03h, and page 01h when it is built, are read-only to the host. The device port loads them, with `dev_page` naming the page and `dev_addr` bit 7 set.
- R7: When the page register names a page that is not built (01h when omitted, 02h when omitted, or 04h to FFh), the register keeps the written value. The upper half then reads 00h, and host writes to it change no page.
- R8: Address 128 of page 00h returns the value held in lower byte 0.
- R9: With `host_seq` low, an access uses `host_addr`. With `host_seq` high, it uses the internal pointer. After every access the pointer becomes the used address plus one, wrapping 127 to 0 and 255 to 128.
- R10: A read updates `host_rdata` at the clock edge where `host_rd` is high. The value then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_seq | input | 1 | Use the internal pointer instead of `host_addr` |
| host_addr | input | 8 | Host byte address (random access) |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered read data |
| dev_wr | input | 1 | Device load strobe |
| dev_page | input | 8 | Target upper page for a device load |
| dev_addr | input | 8 | Device byte address; bit 7 selects the upper half |
| dev_wdata | input | 8 | Device load data |

## Verification
The bench builds the map with the optional page 01h left out and the scratch page 02h built in. This puts an unbuilt page in the middle of the valid range, next to a writable one. Selecting page 01h can then show that upper reads return 00h while the scratch contents survive the blocked write. The same build also lets the bench select an out-of-range page. With page 02h selected, sequential runs can cross both wrap points and show the pointer staying inside its half, including the step from the page register back to the identifier byte.

// File: rtl/mgmt_map_pkg.sv
package mgmt_map_pkg;

    localparam int BYTE_W        = 8;
    localparam int HALF_BYTES    = 128;
    localparam int IDX_W         = $clog2(HALF_BYTES);
    localparam int FIRST_RW_IDX  = 86;
    localparam int PAGE_REG_IDX  = HALF_BYTES - 1;
    localparam int NUM_PAGE_SLOTS = 4;

    typedef enum logic {
        ACC_RO = 1'b0,
        ACC_RW = 1'b1
    } acc_e;

    typedef struct packed {
        logic              wr;
        logic              rd;
        logic [7:0]        addr;
        logic [BYTE_W-1:0] data;
    } host_req_t;

    function automatic acc_e lower_access(input int idx);
        return (idx >= FIRST_RW_IDX) ? ACC_RW : ACC_RO;
    endfunction

    // advance within the current half: bit 7 is kept, low bits wrap
    function automatic logic [7:0] step_addr(input logic [7:0] a);
        return {a[7], a[6:0] + 7'd1};
    endfunction

    function automatic logic page_present(input logic [7:0] pg,
                                          input logic has_p1,
                                          input logic has_p2);
        case (pg)
            8'h00, 8'h03: return 1'b1;
            8'h01:        return has_p1;
            8'h02:        return has_p2;
            default:      return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/mgmt_addr_ctrl.sv
module mgmt_addr_ctrl
    import mgmt_map_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       access,
    input  logic       seq,
    input  logic [7:0] addr_in,
    output logic [7:0] eff_addr
);

    logic [7:0] ptr_q;

    assign eff_addr = seq ? ptr_q : addr_in;

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= 8'h00;
        else if (access)
            ptr_q <= step_addr(eff_addr);
    end

    // R9: the pointer stays inside the half it is walking
    p_low_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (access && eff_addr == 8'd127) |=> (ptr_q == 8'd0));
    p_high_wrap_r9: assert property (@(posedge clk) disable iff (rst)
        (access && eff_addr == 8'd255) |=> (ptr_q == 8'd128));

endmodule

// File: rtl/mgmt_lower_bank.sv
module mgmt_lower_bank
    import mgmt_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  host_idx,
    input  logic [BYTE_W-1:0] host_data,
    input  logic              dev_we,
    input  logic [IDX_W-1:0]  dev_idx,
    input  logic [BYTE_W-1:0] dev_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_data,
    output logic [BYTE_W-1:0] id_byte
);

    logic [BYTE_W-1:0] mem [HALF_BYTES];

    for (genvar i = 0; i < HALF_BYTES; i++) begin : g_byte
        if (i == PAGE_REG_IDX) begin : g_pagereg_slot
            // the page register lives in the top module
            always_ff @(posedge clk) mem[i] <= '0;
        end else if (lower_access(i) == ACC_RW) begin : g_rw
            always_ff @(posedge clk) begin
                if (rst)
                    mem[i] <= '0;
                else if (host_we && host_idx == IDX_W'(i))
                    mem[i] <= host_data;
            end
        end else begin : g_ro
            always_ff @(posedge clk) begin
                if (rst)
                    mem[i] <= '0;
                else if (dev_we && dev_idx == IDX_W'(i))
                    mem[i] <= dev_data;
            end
            // R3: a read-only byte moves only on a device load
            p_ro_hold_r3: assert property (@(posedge clk) disable iff (rst)
                !(dev_we && dev_idx == IDX_W'(i)) |=> $stable(mem[i]));
        end
    end

    assign rd_data = mem[rd_idx];
    assign id_byte = mem[0];

endmodule

// File: rtl/mgmt_upper_pages.sv
module mgmt_upper_pages
    import mgmt_map_pkg::*;
#(
    parameter bit HAS_PAGE1 = 1'b0,
    parameter bit HAS_PAGE2 = 1'b1
)(
    input  logic              clk,
    input  logic              rst,
    input  logic [7:0]        page_sel,
    input  logic              host_we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [BYTE_W-1:0] host_data,
    input  logic              dev_we,
    input  logic [7:0]        dev_page,
    input  logic [IDX_W-1:0]  dev_idx,
    input  logic [BYTE_W-1:0] dev_data,
    input  logic [BYTE_W-1:0] id_byte,
    output logic [BYTE_W-1:0] rd_data
);

    logic [BYTE_W-1:0] page_out [NUM_PAGE_SLOTS];
    logic              sel_present;

    for (genvar p = 0; p < NUM_PAGE_SLOTS; p++) begin : g_page
        localparam bit BUILT = (p == 0) || (p == 3) ||
                               (p == 1 && HAS_PAGE1) || (p == 2 && HAS_PAGE2);
        localparam bit HOST_RW = (p == 2);
        if (BUILT) begin : g_built
            logic [BYTE_W-1:0] store [HALF_BYTES];
            logic              we;
            logic [IDX_W-1:0]  widx;
            logic [BYTE_W-1:0] wdat;
            if (HOST_RW) begin : g_host
                assign we   = host_we && page_sel == 8'(p);
                assign widx = idx;
                assign wdat = host_data;
            end else begin : g_dev
                assign we   = dev_we && dev_page == 8'(p);
                assign widx = dev_idx;
                assign wdat = dev_data;
            end
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int k = 0; k < HALF_BYTES; k++) store[k] <= '0;
                end else if (we) begin
                    store[widx] <= wdat;
                end
            end
            assign page_out[p] = store[idx];
        end else begin : g_absent
            assign page_out[p] = '0;
        end
    end

    assign sel_present = page_present(page_sel, HAS_PAGE1, HAS_PAGE2);

    always_comb begin
        if (!sel_present)
            rd_data = '0;
        else if (page_sel == 8'h00 && idx == '0)
            rd_data = id_byte;
        else
            rd_data = page_out[page_sel[1:0]];
    end

    // R7: an unbuilt page returns zeros
    p_absent_zero_r7: assert property (@(posedge clk) disable iff (rst)
        !page_present(page_sel, HAS_PAGE1, HAS_PAGE2) |-> (rd_data == '0));
    // R8: the first byte of page 00h mirrors the identifier
    p_id_mirror_r8: assert property (@(posedge clk) disable iff (rst)
        (page_sel == 8'h00 && idx == '0) |-> (rd_data == id_byte));

endmodule

// File: rtl/mgmt_paged_regmap.sv
module mgmt_paged_regmap
    import mgmt_map_pkg::*;
#(
    parameter bit HAS_PAGE1 = 1'b0,
    parameter bit HAS_PAGE2 = 1'b1
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic       host_rd,
    input  logic       host_seq,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    input  logic       dev_wr,
    input  logic [7:0] dev_page,
    input  logic [7:0] dev_addr,
    input  logic [7:0] dev_wdata
);

    host_req_t         req;
    logic [7:0]        eff_addr;
    logic [7:0]        page_q;
    logic              hit_page_reg;
    logic [BYTE_W-1:0] lo_rd, up_rd, id_byte, rd_mux;

    always_comb begin
        req.wr   = host_wr;
        req.rd   = host_rd;
        req.addr = eff_addr;
        req.data = host_wdata;
    end

    mgmt_addr_ctrl u_addr (
        .clk      (clk),
        .rst      (rst),
        .access   (host_wr | host_rd),
        .seq      (host_seq),
        .addr_in  (host_addr),
        .eff_addr (eff_addr)
    );

    assign hit_page_reg = (req.addr == 8'(PAGE_REG_IDX));

    always_ff @(posedge clk) begin
        if (rst)
            page_q <= 8'h00;
        else if (req.wr && hit_page_reg)
            page_q <= req.data;
    end

    mgmt_lower_bank u_lower (
        .clk       (clk),
        .rst       (rst),
        .host_we   (req.wr && !req.addr[7] && !hit_page_reg),
        .host_idx  (req.addr[IDX_W-1:0]),
        .host_data (req.data),
        .dev_we    (dev_wr && !dev_addr[7]),
        .dev_idx   (dev_addr[IDX_W-1:0]),
        .dev_data  (dev_wdata),
        .rd_idx    (req.addr[IDX_W-1:0]),
        .rd_data   (lo_rd),
        .id_byte   (id_byte)
    );

    mgmt_upper_pages #(
        .HAS_PAGE1 (HAS_PAGE1),
        .HAS_PAGE2 (HAS_PAGE2)
    ) u_upper (
        .clk       (clk),
        .rst       (rst),
        .page_sel  (page_q),
        .host_we   (req.wr && req.addr[7]),
        .idx       (req.addr[IDX_W-1:0]),
        .host_data (req.data),
        .dev_we    (dev_wr && dev_addr[7]),
        .dev_page  (dev_page),
        .dev_idx   (dev_addr[IDX_W-1:0]),
        .dev_data  (dev_wdata),
        .id_byte   (id_byte),
        .rd_data   (up_rd)
    );

    always_comb begin
        if (req.addr[7])
            rd_mux = up_rd;
        else if (hit_page_reg)
            rd_mux = page_q;
        else
            rd_mux = lo_rd;
    end

    always_ff @(posedge clk) begin
        if (rst)
            host_rdata <= '0;
        else if (req.rd)
            host_rdata <= rd_mux;
    end

    // R4: page register leaves reset at page 00h
    p_page_reset_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (page_q == 8'h00));
    // R10: read data holds between reads
    p_rdata_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !host_rd |=> $stable(host_rdata));
    // R4: the page register moves only on a host write to byte 127
    p_page_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !(host_wr && eff_addr == 8'd127) |=> $stable(page_q));

endmodule

// File: tb/sim_mgmt_paged_regmap.sv
module sim_mgmt_paged_regmap;

    localparam logic [1:0] OP_WR  = 2'd0;
    localparam logic [1:0] OP_RD  = 2'd1;
    localparam logic [1:0] OP_DEV = 2'd2;

    typedef struct packed {
        logic [1:0] op;
        logic [7:0] addr;
        logic [7:0] pg;
        logic [7:0] data;
        logic [7:0] exp;
        logic [3:0] req;
    } vec_t;

    localparam int NVEC = 30;
    localparam vec_t TBL [NVEC] = '{
        '{OP_DEV, 8'd3,    8'h00, 8'hA5, 8'h00, 4'd3},  // R3 device loads a flag byte
        '{OP_RD,  8'd3,    8'h00, 8'h00, 8'hA5, 4'd3},
        '{OP_WR,  8'd3,    8'h00, 8'h5A, 8'h00, 4'd3},  // R3 host write ignored
        '{OP_RD,  8'd3,    8'h00, 8'h00, 8'hA5, 4'd3},
        '{OP_WR,  8'd90,   8'h00, 8'h3C, 8'h00, 4'd2},  // R2 control byte
        '{OP_RD,  8'd90,   8'h00, 8'h00, 8'h3C, 4'd2},
        '{OP_DEV, 8'd90,   8'h00, 8'hFF, 8'h00, 4'd2},  // R2 device cannot touch it
        '{OP_RD,  8'd90,   8'h00, 8'h00, 8'h3C, 4'd2},
        '{OP_DEV, 8'd0,    8'h00, 8'h0D, 8'h00, 4'd8},  // R8 identifier
        '{OP_RD,  8'd128,  8'h00, 8'h00, 8'h0D, 4'd8},
        '{OP_DEV, 8'h85,   8'h03, 8'h77, 8'h00, 4'd6},  // R6 load page 03h
        '{OP_WR,  8'h85,   8'h00, 8'h11, 8'h00, 4'd6},  // R6 page 00h read-only
        '{OP_RD,  8'h85,   8'h00, 8'h00, 8'h00, 4'd6},
        '{OP_WR,  8'd127,  8'h00, 8'h03, 8'h00, 4'd4},  // R4 select page 03h
        '{OP_RD,  8'd127,  8'h00, 8'h00, 8'h03, 4'd4},
        '{OP_RD,  8'h85,   8'h00, 8'h00, 8'h77, 4'd5},  // R5
        '{OP_WR,  8'h85,   8'h00, 8'h22, 8'h00, 4'd6},  // R6 page 03h read-only
        '{OP_RD,  8'h85,   8'h00, 8'h00, 8'h77, 4'd6},
        '{OP_WR,  8'd127,  8'h00, 8'h02, 8'h00, 4'd5},  // R5 scratch page
        '{OP_WR,  8'h90,   8'h00, 8'h5E, 8'h00, 4'd5},
        '{OP_RD,  8'h90,   8'h00, 8'h00, 8'h5E, 4'd5},
        '{OP_RD,  8'd90,   8'h00, 8'h00, 8'h3C, 4'd2},  // R2 lower independent of page
        '{OP_WR,  8'd127,  8'h00, 8'h01, 8'h00, 4'd7},  // R7 unbuilt page 01h
        '{OP_RD,  8'd127,  8'h00, 8'h00, 8'h01, 4'd7},
        '{OP_WR,  8'h90,   8'h00, 8'h99, 8'h00, 4'd7},
        '{OP_RD,  8'h90,   8'h00, 8'h00, 8'h00, 4'd7},
        '{OP_WR,  8'd127,  8'h00, 8'h07, 8'h00, 4'd7},  // R7 out-of-range page
        '{OP_RD,  8'h90,   8'h00, 8'h00, 8'h00, 4'd7},
        '{OP_WR,  8'd127,  8'h00, 8'h02, 8'h00, 4'd7},
        '{OP_RD,  8'h90,   8'h00, 8'h00, 8'h5E, 4'd7}   // R7 scratch untouched
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0, host_rd = 1'b0, host_seq = 1'b0;
    logic [7:0] host_addr = '0, host_wdata = '0, host_rdata;
    logic       dev_wr = 1'b0;
    logic [7:0] dev_page = '0, dev_addr = '0, dev_wdata = '0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    mgmt_paged_regmap #(.HAS_PAGE1(1'b0), .HAS_PAGE2(1'b1)) u0 (
        .clk, .rst, .host_wr, .host_rd, .host_seq, .host_addr, .host_wdata,
        .host_rdata, .dev_wr, .dev_page, .dev_addr, .dev_wdata
    );

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] a, input logic [7:0] d, input logic s);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d; host_seq = s;
        @(negedge clk);
        host_wr = 1'b0; host_seq = 1'b0;
    endtask

    task automatic host_read(input logic [7:0] a, input logic s,
                             input logic [7:0] exp, input string tag);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a; host_seq = s;
        @(negedge clk);
        host_rd = 1'b0; host_seq = 1'b0;
        check(tag, host_rdata, exp);
    endtask

    task automatic dev_load(input logic [7:0] pg, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        dev_wr = 1'b1; dev_page = pg; dev_addr = a; dev_wdata = d;
        @(negedge clk);
        dev_wr = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 rdata after reset", host_rdata, 8'h00);
        host_read(8'd127, 1'b0, 8'h00, "R1 page register after reset");
        host_read(8'd100, 1'b0, 8'h00, "R1 mask byte after reset");
        host_read(8'd200, 1'b0, 8'h00, "R1 upper byte after reset");

        for (int i = 0; i < NVEC; i++) begin
            case (TBL[i].op)
                OP_WR:   host_write(TBL[i].addr, TBL[i].data, 1'b0);
                OP_DEV:  dev_load(TBL[i].pg, TBL[i].addr, TBL[i].data);
                default: host_read(TBL[i].addr, 1'b0, TBL[i].exp,
                                   $sformatf("R%0d vector %0d", TBL[i].req, i));
            endcase
        end

        // R9 sequential writes crossing 255 -> 128 on page 02h
        host_write(8'd254, 8'hA1, 1'b0);
        host_write(8'h00,  8'hB2, 1'b1);
        host_write(8'h00,  8'hC3, 1'b1);
        host_read(8'd254, 1'b0, 8'hA1, "R9 seq write start");
        host_read(8'h00,  1'b1, 8'hB2, "R9 seq read 255");
        host_read(8'h00,  1'b1, 8'hC3, "R9 seq wrap to 128");
        // R9 sequential reads crossing 127 -> 0
        host_read(8'd126, 1'b0, 8'h00, "R9 password byte");
        host_read(8'h55,  1'b1, 8'h02, "R9 seq reaches page register");
        host_read(8'h55,  1'b1, 8'h0D, "R9 seq wrap to identifier");

        // R10 rdata holds across idle cycles and writes
        repeat (3) @(negedge clk);
        check("R10 hold after idle", host_rdata, 8'h0D);
        host_write(8'd95, 8'h44, 1'b0);
        check("R10 hold across write", host_rdata, 8'h0D);

        // R1 mid-run reset clears page register and stored bytes
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 rdata cleared", host_rdata, 8'h00);
        host_read(8'd127, 1'b0, 8'h00, "R1 page register cleared");
        host_read(8'd90,  1'b0, 8'h00, "R1 control byte cleared");
        host_read(8'd3,   1'b0, 8'h00, "R1 flag byte cleared");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule